// File: doc/BRIEF.md
# Priority Interrupt Controller With Force Register

This block gathers fifteen interrupt levels (1 to 15) into a set of pending bits and hands the processor a 4-bit request code naming the highest level that is pending and not masked. Sources arrive as single-cycle pulses, one bit per level. A separate overrun pulse from the serial ports lands on level 7. The processor takes an interrupt by presenting the level on the acknowledge input, and the controller then drops that level.

Software reaches the controller through a small write port with four targets: a mask, a write-one-to-clear register, a force register and a test control word. In test mode, bits written to the force register are merged into the pending set. This lets a test provoke any level without a real source. An acknowledge in test mode removes a forced bit before it touches the real pending bit. The pending, mask and force contents and the test-mode flag are visible on read outputs.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the pending, mask and force sets are all zero, test mode is off, `irq_lvl` is 0 and `par_err` is 0.
- R2: A 1 on bit k (k = 1..15) of `src_evt` sets pending bit k at the next clock edge. Bit 0 of `src_evt` is ignored. A pulse on `ovr_evt` sets pending bit 7.
- R3: A mask write (`wr_sel` = 0) stores bits 14:1 of `wr_data` as the mask. Mask bits 0 and 15 always read 0, so level 15 can never be masked.
- R4: A mask write with bit 0 or any of bits 31:15 of `wr_data` set raises `par_err` for exactly one cycle, in the cycle after the write.
- R5: A clear write (`wr_sel` = 1) drops pending bit k for every k in 1..15 where bit k of `wr_data` is 1. It leaves the other bits alone.
- R6: A test control write (`wr_sel` = 3) sets test mode to bit 19 of `wr_data`. A force write (`wr_sel` = 2) loads bits 15:1 into the force set only while test mode is on; otherwise it has no effect. Force bits join the request only while test mode is on.
- R7: `irq_lvl` holds the highest level k in 15..1 whose bit is set in (pending OR force-if-test) and clear in the mask, or 0 if none. It is registered, so it follows the state one clock later.
- R8: An acknowledge of level k (`ack_vld` with `ack_lvl` = k) clears force bit k if test mode is on and that bit is set. Otherwise it clears pending bit k. Level 0 has no effect.
- R9: When a source event and a clear (acknowledge or clear write) hit the same level in the same cycle, the event wins and the bit stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | 16 | One pulse bit per level, bit 0 unused |
| ovr_evt | input | 1 | Serial overrun pulse, raises level 7 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mask, 1 clear, 2 force, 3 test control |
| wr_data | input | 32 | Write data |
| ack_vld | input | 1 | Acknowledge strobe |
| ack_lvl | input | 4 | Level being acknowledged |
| irq_lvl | output | 4 | Registered request level, 0 for none |
| pend_rd | output | 16 | Pending set |
| mask_rd | output | 16 | Mask set |
| force_rd | output | 16 | Force set |
| test_on | output | 1 | Test mode flag |
| par_err | output | 1 | One-cycle pulse on an illegal mask write |

## Verification
Two of the controller's functions can land on one level in the same cycle: raising a pending bit from a source, and dropping it through an acknowledge or a clear write. The bench drives a source pulse together with an acknowledge of that level, and in another case together with a clear write covering it. In both cases it expects the bit to stay pending and the request to still name the level. A second collision, an acknowledge on a level that is both forced and pending in test mode, is judged by the force bit alone going away.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int unsigned LVL_HI   = 15;
    localparam int unsigned VEC_W    = LVL_HI + 1;
    localparam int unsigned ID_W     = $clog2(VEC_W);
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned TEST_BIT = 19;
    localparam int unsigned OVR_LVL  = 7;

    typedef logic [VEC_W-1:0] lvl_vec_t;

    // Levels that exist (1..LVL_HI) and levels that may be masked (1..LVL_HI-1)
    localparam lvl_vec_t PEND_KEEP = lvl_vec_t'((32'd1 << VEC_W) - 32'd2);
    localparam lvl_vec_t MASK_KEEP = lvl_vec_t'((32'd1 << LVL_HI) - 32'd2);

    typedef enum logic [1:0] {
        SEL_MASK  = 2'd0,
        SEL_CLR   = 2'd1,
        SEL_FORCE = 2'd2,
        SEL_TEST  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic            vld;
        logic [ID_W-1:0] lvl;
    } ack_t;

    typedef struct packed {
        logic              en;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic [ID_W-1:0] top_level(lvl_vec_t v);
        logic [ID_W-1:0] r;
        r = '0;
        for (int i = 1; i <= int'(LVL_HI); i++) begin
            if (v[i]) r = ID_W'(i);
        end
        return r;
    endfunction

    function automatic lvl_vec_t level_bit(logic [ID_W-1:0] l);
        lvl_vec_t r;
        r = '0;
        r[l] = 1'b1;
        return r & PEND_KEEP;
    endfunction

endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
    import prio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wr_req_t  wr,
    input  ack_t     ack,
    output lvl_vec_t mask_q,
    output lvl_vec_t force_q,
    output logic     test_q,
    output logic     par_err_q
);

    logic     mask_wr;
    logic     force_wr;
    logic     bad_bits;
    lvl_vec_t force_ack_clr;

    assign mask_wr  = wr.en && (wr.sel == SEL_MASK);
    assign force_wr = wr.en && (wr.sel == SEL_FORCE) && test_q;
    assign bad_bits = |(wr.data & ~DATA_W'(MASK_KEEP));

    // Forced bit taken by an acknowledge in test mode
    always_comb begin
        force_ack_clr = '0;
        if (ack.vld && test_q && force_q[ack.lvl]) begin
            force_ack_clr = level_bit(ack.lvl);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q    <= '0;
            force_q   <= '0;
            test_q    <= 1'b0;
            par_err_q <= 1'b0;
        end else begin
            par_err_q <= mask_wr && bad_bits;
            if (mask_wr) begin
                mask_q <= wr.data[VEC_W-1:0] & MASK_KEEP;
            end
            if (wr.en && (wr.sel == SEL_TEST)) begin
                test_q <= wr.data[TEST_BIT];
            end
            if (force_wr) begin
                force_q <= wr.data[VEC_W-1:0] & PEND_KEEP;
            end else begin
                force_q <= force_q & ~force_ack_clr;
            end
        end
    end

endmodule

// File: rtl/prio_irq_pend.sv
module prio_irq_pend
    import prio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lvl_vec_t set_vec,
    input  lvl_vec_t clr_vec,
    output lvl_vec_t pend_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            // Set applied after clear: a new event outlives a same-cycle clear
            pend_q <= ((pend_q & ~clr_vec) | set_vec) & PEND_KEEP;
        end
    end

endmodule

// File: rtl/prio_irq_enc.sv
module prio_irq_enc
    import prio_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  lvl_vec_t        pend,
    input  lvl_vec_t        force_v,
    input  logic            test,
    input  lvl_vec_t        mask,
    output logic [ID_W-1:0] irq_q
);

    lvl_vec_t live;

    assign live = (pend | (test ? force_v : '0)) & ~mask & PEND_KEEP;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
        end else begin
            irq_q <= top_level(live);
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [VEC_W-1:0]  src_evt,
    input  logic              ovr_evt,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ack_vld,
    input  logic [ID_W-1:0]   ack_lvl,
    output logic [ID_W-1:0]   irq_lvl,
    output logic [VEC_W-1:0]  pend_rd,
    output logic [VEC_W-1:0]  mask_rd,
    output logic [VEC_W-1:0]  force_rd,
    output logic              test_on,
    output logic              par_err
);

    wr_req_t  wr;
    ack_t     ack;
    lvl_vec_t mask_q;
    lvl_vec_t force_q;
    lvl_vec_t pend_q;
    logic     test_q;
    lvl_vec_t set_vec;
    lvl_vec_t clr_vec;
    lvl_vec_t ovr_vec;

    assign wr.en   = wr_en;
    assign wr.sel  = reg_sel_e'(wr_sel);
    assign wr.data = wr_data;
    assign ack.vld = ack_vld;
    assign ack.lvl = ack_lvl;

    always_comb begin
        ovr_vec = '0;
        ovr_vec[OVR_LVL] = ovr_evt;
    end

    assign set_vec = (src_evt | ovr_vec) & PEND_KEEP;

    // Clear from software write and from an acknowledge not absorbed by a force bit
    always_comb begin
        clr_vec = '0;
        if (wr.en && (wr.sel == SEL_CLR)) begin
            clr_vec = wr.data[VEC_W-1:0] & PEND_KEEP;
        end
        if (ack.vld && !(test_q && force_q[ack.lvl])) begin
            clr_vec = clr_vec | level_bit(ack.lvl);
        end
    end

    prio_irq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .ack       (ack),
        .mask_q    (mask_q),
        .force_q   (force_q),
        .test_q    (test_q),
        .par_err_q (par_err)
    );

    prio_irq_pend u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .pend_q  (pend_q)
    );

    prio_irq_enc u_enc (
        .clk     (clk),
        .rst     (rst),
        .pend    (pend_q),
        .force_v (force_q),
        .test    (test_q),
        .mask    (mask_q),
        .irq_q   (irq_lvl)
    );

    assign pend_rd  = pend_q;
    assign mask_rd  = mask_q;
    assign force_rd = force_q;
    assign test_on  = test_q;

endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk
    import prio_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [VEC_W-1:0]  src_evt,
    input logic              ovr_evt,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              ack_vld,
    input logic [ID_W-1:0]   ack_lvl,
    input logic [ID_W-1:0]   irq_lvl,
    input logic [VEC_W-1:0]  pend_rd,
    input logic [VEC_W-1:0]  mask_rd,
    input logic [VEC_W-1:0]  force_rd,
    input logic              test_on,
    input logic              par_err
);

    localparam logic [VEC_W-1:0] LVL_BITS = PEND_KEEP;

    // R2 / R9: every source bit is pending one edge later, whatever else happens
    a_r9_event_wins: assert property (@(posedge clk) disable iff (rst)
        ((src_evt & LVL_BITS) != '0) |=>
            ((pend_rd & $past(src_evt & LVL_BITS)) == $past(src_evt & LVL_BITS)));

    // R3: mask write keeps bits 14:1
    a_r3_mask_store: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0) |=> (mask_rd[VEC_W-2:1] == $past(wr_data[VEC_W-2:1])));

    // R4: illegal mask bits give a parity pulse
    a_r4_par_pulse: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0 && (wr_data[0] || (wr_data[DATA_W-1:VEC_W-1] != '0)))
            |=> par_err);

    // R4: no pulse without a mask write the cycle before
    a_r4_par_cause: assert property (@(posedge clk) disable iff (rst)
        par_err |-> $past(wr_en && wr_sel == 2'd0));

    // R5: a clear write with no source activity leaves the written bits low
    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd1 && src_evt == '0 && !ovr_evt) |=>
            ((pend_rd & $past(wr_data[VEC_W-1:0]) & LVL_BITS) == '0));

    // R6: force write outside test mode changes nothing
    a_r6_force_locked: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd2 && !test_on) |=> $stable(force_rd));

    // R7: nothing live gives a zero request
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
        ($past(pend_rd) == '0 && ($past(force_rd) == '0 || !$past(test_on))) |-> irq_lvl == '0);

    // R7: a nonzero request names a level that was live
    a_r7_level_live: assert property (@(posedge clk) disable iff (rst)
        (irq_lvl != '0) |->
            ((((($past(pend_rd) | ($past(test_on) ? $past(force_rd) : '0))
                & ~$past(mask_rd)) >> irq_lvl) & VEC_W'(1)) != '0));

    // R8: ack on a forced level in test mode spares the pending bit
    a_r8_force_first: assert property (@(posedge clk) disable iff (rst)
        (ack_vld && test_on && force_rd[ack_lvl] && ack_lvl != '0 &&
         !(wr_en && wr_sel != 2'd0)) |=>
            (((force_rd >> $past(ack_lvl)) & VEC_W'(1)) == '0) &&
            (((pend_rd >> $past(ack_lvl)) & VEC_W'(1)) == (($past(pend_rd) >> $past(ack_lvl)) & VEC_W'(1))));

endmodule

bind prio_irq_ctrl prio_irq_chk u_chk (.*);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src_evt = '0;
    logic        ovr_evt = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        ack_vld = 1'b0;
    logic [3:0]  ack_lvl = '0;
    logic [3:0]  irq_lvl;
    logic [15:0] pend_rd, mask_rd, force_rd;
    logic        test_on, par_err;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    prio_irq_ctrl u_dut (.*);

    function automatic int hi_lvl(int v);
        int r = 0;
        for (int i = 1; i < 16; i++) if ((v >> i) & 1) r = i;
        return r;
    endfunction

    task automatic check(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(int sel, int data);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 32'(data);
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(int bits);
        src_evt = 16'(bits);
        tick();
        src_evt = '0;
    endtask

    task automatic ack(int l);
        ack_vld = 1'b1; ack_lvl = 4'(l);
        tick();
        ack_vld = 1'b0; ack_lvl = '0;
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1 pend", pend_rd, 0);
        check("R1 mask", mask_rd, 0);
        check("R1 force", force_rd, 0);
        check("R1 test", test_on, 0);
        check("R1 irq", irq_lvl, 0);
        check("R1 par", par_err, 0);

        // R2 / R7 / R8: each level alone, then acknowledged
        for (int k = 1; k < 16; k++) begin
            pulse(1 << k);
            check("R2 set", pend_rd, 1 << k);
            tick();
            check("R7 single", irq_lvl, k);
            ack(k);
            check("R8 ack pend", pend_rd, 0);
        end
        // R2 bit 0 ignored
        pulse(1);
        check("R2 bit0", pend_rd, 0);
        // R2 overrun on level 7
        ovr_evt = 1'b1; tick(); ovr_evt = 1'b0;
        check("R2 ovr", pend_rd, 1 << 7);
        wr(1, 32'hFFFE);
        check("R5 clear all", pend_rd, 0);

        // R7 / R3 sweep of patterns and masks
        for (int i = 0; i < 96; i++) begin
            int p, m;
            p = ((i * 40503) ^ (i << 9)) & 16'hFFFE;
            m = ((i * 7919) >> 2) & 16'hFFFE;
            wr(1, 32'hFFFE);
            wr(0, m);
            pulse(p);
            tick();
            check("R7 sweep", irq_lvl, hi_lvl(p & ~m & 16'h7FFE | p & 16'h8000));
        end

        // R3 / R4 mask with bit 15 and bit 0
        wr(1, 32'hFFFE);
        wr(0, 32'h0000_FFFF);
        check("R4 par pulse", par_err, 1);
        check("R3 mask bits", mask_rd, 16'h7FFE);
        pulse(1 << 15 | 1 << 3);
        check("R4 par single", par_err, 0);
        tick();
        check("R3 l15 unmasked", irq_lvl, 15);
        wr(0, 32'h0008_0000);
        check("R4 par high", par_err, 1);
        wr(0, 32'h0000_7FFE);
        check("R4 par legal", par_err, 0);
        wr(0, 0);

        // R5 selective clear
        wr(1, 32'hFFFE);
        pulse(16'h00F0);
        wr(1, 32'h0030);
        check("R5 partial", pend_rd, 16'h00C0);

        // R9 event vs clear write and vs ack
        src_evt = 16'h0040; wr(1, 32'h0040); src_evt = '0;
        check("R9 vs clear", pend_rd & 16'h0040, 16'h0040);
        src_evt = 16'h0080; ack_vld = 1; ack_lvl = 7; tick();
        src_evt = '0; ack_vld = 0;
        check("R9 vs ack", pend_rd & 16'h0080, 16'h0080);
        tick();
        check("R9 irq", irq_lvl, 7);
        wr(1, 32'hFFFE);

        // R6 force locked outside test mode
        wr(2, 32'h0000_0400);
        check("R6 force locked", force_rd, 0);
        wr(3, 32'h0008_0000);
        check("R6 test on", test_on, 1);
        wr(2, 32'h0000_0401);
        check("R6 force load", force_rd, 16'h0400);
        tick();
        check("R6 force req", irq_lvl, 10);
        // R8 force cleared before pending
        pulse(1 << 10);
        ack(10);
        check("R8 force cleared", force_rd, 0);
        check("R8 pend kept", pend_rd, 1 << 10);
        ack(10);
        check("R8 pend cleared", pend_rd, 0);
        ack(0);
        check("R8 level0", pend_rd, 0);
        // R6 force ignored once test mode is off
        wr(2, 32'h0000_2000);
        wr(3, 0);
        tick();
        check("R6 test off irq", irq_lvl, 0);
        check("R6 force kept", force_rd, 16'h2000);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule